// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This unit performs 32x32 integer multiplication and division, signed or unsigned, and keeps the results in two 32-bit result registers, HI and LO. The same port also carries direct moves into HI or LO and reads from them. Every result is stored at issue. A countdown of the modelled latency makes a read of HI or LO wait until that time has passed. The requester holds a read request on the port while `stall` is high. The read completes, with `rd_valid` high, in the first cycle in which the unit is not busy.

Control is a two-state machine. In IDLE the countdown is zero and reads complete at once. In BUSY the countdown is non-zero. The transition IDLE->BUSY (issue) fires when a multiply or divide is accepted and loads the countdown. BUSY->BUSY (restart) fires when another multiply or divide arrives and reloads the countdown. BUSY->BUSY (tick) decrements the countdown. BUSY->IDLE (drain) fires when the countdown steps from 1 to 0.

Top module: `hilo_muldiv`

## Requirements
- R1: After reset, HI and LO read as 0, `busy` is low, and a read completes with no stall.
- R2: A signed multiply (op_code 0) leaves the 64-bit two's complement product of src_a and src_b with bits 63:32 in HI and bits 31:0 in LO.
- R3: An unsigned multiply (op_code 1) leaves the 64-bit unsigned product with the same split between HI and LO.
- R4: Multiply latency is 7 + (2 - lz/11)*4 cycles, using integer division. For an unsigned multiply, lz is the leading-zero count of (src_a | 1). For a signed multiply, lz is the leading-zero count of ((src_a XOR (src_a shifted right arithmetically by 21)) | 1). The only possible values are 7, 11 and 15.
- R5: A signed divide (op_code 2) or unsigned divide (op_code 3) puts the quotient in LO and the remainder in HI, and has a latency of 37 cycles. A signed quotient truncates toward zero, and the signed remainder takes the sign of the dividend.
- R6: A signed divide by zero sets HI to the dividend. It sets LO to 1 when the dividend is negative and to 0xFFFFFFFF otherwise.
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R8: An unsigned divide by zero sets LO to 0xFFFFFFFF and HI to the dividend.
- R9: A read of HI (op_code 6) or LO (op_code 7) presented while the countdown is non-zero raises `stall` and is held. It completes with `rd_valid` in the first cycle in which `busy` is low. A read presented in the cycle right after an operation with latency L is issued stalls for exactly L cycles, and a read presented g cycles later stalls for max(L-g, 0) cycles.
- R10: A move into HI (op_code 4) or LO (op_code 5) writes src_a at the next edge, even while busy, and does not change the countdown.
- R11: A multiply or divide issued while busy restarts the countdown with its own latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request present on op_code/src_a/src_b |
| op_code | input | 3 | Operation code (see R2-R10) |
| src_a | input | 32 | First operand / dividend / move source |
| src_b | input | 32 | Second operand / divisor |
| rd_data | output | 32 | HI or LO value for a completing read |
| rd_valid | output | 1 | Read completes this cycle |
| busy | output | 1 | Countdown is non-zero |
| stall | output | 1 | Presented read is being held |

## Verification
A multiply or divide is driven at a falling edge and is accepted at the next rising edge. From that edge the result is due L rising edges later, where L is 7, 11, 15 or 37. The bench predicts L for each operand and drives the HI read in the cycle right after issue. It samples `stall` shortly after each falling edge and counts the held cycles, which must equal L, and then compares `rd_data` in the release cycle. A second read of LO then must complete with zero stall cycles. Further runs read after idle gaps, insert moves while busy, and issue a new operation before the old one drains, and each of these runs checks the shortened, unchanged or restarted stall count.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
    localparam int XLEN = 32;

    typedef enum logic [2:0] {
        OP_MULS = 3'd0,
        OP_MULU = 3'd1,
        OP_DIVS = 3'd2,
        OP_DIVU = 3'd3,
        OP_WRHI = 3'd4,
        OP_WRLO = 3'd5,
        OP_RDHI = 3'd6,
        OP_RDLO = 3'd7
    } hl_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } hl_state_e;
endpackage

// File: rtl/mul_latency.sv
module mul_latency #(
    parameter int XLEN  = 32,
    parameter int BASE  = 7,
    parameter int STEP  = 4,
    parameter int SEG   = 11,
    parameter int SHIFT = 21,
    parameter int CW    = 6
) (
    input  logic            signed_mode,
    input  logic [XLEN-1:0] a,
    output logic [CW-1:0]   cycles
);
    logic [XLEN-1:0] v;
    int              lz;
    logic            found;

    always_comb begin
        if (signed_mode)
            v = (a ^ XLEN'($signed(a) >>> SHIFT)) | XLEN'(1);
        else
            v = a | XLEN'(1);
        lz    = 0;
        found = 1'b0;
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (!found) begin
                if (v[i]) found = 1'b1;
                else      lz    = lz + 1;
            end
        end
        cycles = CW'(BASE + (2 - lz / SEG) * STEP);
    end
endmodule

// File: rtl/mul_core.sv
module mul_core #(
    parameter int XLEN = 32
) (
    input  logic              signed_mode,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic [2*XLEN-1:0] prod
);
    logic [2*XLEN-1:0] ea, eb;

    always_comb begin
        if (signed_mode) begin
            ea = {{XLEN{a[XLEN-1]}}, a};
            eb = {{XLEN{b[XLEN-1]}}, b};
        end else begin
            ea = {{XLEN{1'b0}}, a};
            eb = {{XLEN{1'b0}}, b};
        end
        prod = ea * eb;
    end
endmodule

// File: rtl/div_core.sv
module div_core #(
    parameter int XLEN = 32
) (
    input  logic            signed_mode,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] quo,
    output logic [XLEN-1:0] rem
);
    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] ALL_ONES = '1;

    always_comb begin
        if (b == '0) begin
            rem = a;
            if (signed_mode && a[XLEN-1]) quo = XLEN'(1);
            else                          quo = ALL_ONES;
        end else if (signed_mode && a == MOST_NEG && b == ALL_ONES) begin
            quo = MOST_NEG;
            rem = '0;
        end else if (signed_mode) begin
            quo = XLEN'($signed(a) / $signed(b));
            rem = XLEN'($signed(a) % $signed(b));
        end else begin
            quo = a / b;
            rem = a % b;
        end
    end
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
    import hilo_pkg::*;
#(
    parameter int DIV_CYCLES = 37,
    parameter int MUL_BASE   = 7,
    parameter int MUL_STEP   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic [XLEN-1:0] rd_data,
    output logic            rd_valid,
    output logic            busy,
    output logic            stall
);
    localparam int CW = $clog2(DIV_CYCLES + 1);

    hl_state_e         state_q;
    logic [CW-1:0]     cnt_q;
    logic [XLEN-1:0]   hi_q, lo_q;
    hl_op_e            op;
    logic              is_read, is_arith, is_div, sgn, accept, arith_go;
    logic [CW-1:0]     mul_cyc, lat;
    logic [2*XLEN-1:0] prod;
    logic [XLEN-1:0]   quo, rem;

    assign op       = hl_op_e'(op_code);
    assign is_read  = (op_code[2:1] == 2'b11);
    assign is_arith = ~op_code[2];
    assign is_div   = is_arith & op_code[1];
    assign sgn      = ~op_code[0];
    assign accept   = op_valid && !(is_read && busy);
    assign arith_go = accept && is_arith;

    mul_latency #(.XLEN(XLEN), .BASE(MUL_BASE), .STEP(MUL_STEP), .CW(CW)) u_lat (
        .signed_mode(sgn), .a(src_a), .cycles(mul_cyc)
    );
    mul_core #(.XLEN(XLEN)) u_mul (
        .signed_mode(sgn), .a(src_a), .b(src_b), .prod(prod)
    );
    div_core #(.XLEN(XLEN)) u_div (
        .signed_mode(sgn), .a(src_a), .b(src_b), .quo(quo), .rem(rem)
    );

    assign lat = is_div ? CW'(DIV_CYCLES) : mul_cyc;

    // State register and countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (arith_go) begin
                        state_q <= ST_BUSY;
                        cnt_q   <= lat;
                    end
                end
                ST_BUSY: begin
                    if (arith_go) begin
                        cnt_q <= lat;
                    end else if (cnt_q == CW'(1)) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (accept) begin
            unique case (op)
                OP_MULS, OP_MULU: {hi_q, lo_q} <= prod;
                OP_DIVS, OP_DIVU: begin
                    lo_q <= quo;
                    hi_q <= rem;
                end
                OP_WRHI: hi_q <= src_a;
                OP_WRLO: lo_q <= src_a;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q == ST_BUSY);
        stall    = op_valid && is_read && busy;
        rd_valid = op_valid && is_read && !busy;
        rd_data  = '0;
        if (rd_valid) rd_data = op_code[0] ? lo_q : hi_q;
    end

    // R4
    mul_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arith_go && !is_div) |=> (cnt_q == CW'(7) || cnt_q == CW'(11) || cnt_q == CW'(15)));
    // R5
    div_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arith_go && is_div) |=> busy);
    // R6
    sdiv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_DIVS && src_b == '0) |=>
        (hi_q == $past(src_a) && lo_q == ($past(src_a[XLEN-1]) ? XLEN'(1) : {XLEN{1'b1}})));
    // R7
    sdiv_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_DIVS && src_a == 32'h8000_0000 && src_b == 32'hFFFF_FFFF) |=>
        (lo_q == 32'h8000_0000 && hi_q == '0));
    // R8
    udiv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_DIVU && src_b == '0) |=>
        (lo_q == {XLEN{1'b1}} && hi_q == $past(src_a)));
    // R9
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q == CW'(1) && !arith_go) |=> !busy);
    // R10
    move_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_WRHI) |=> (hi_q == $past(src_a)));
    // R10
    move_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !is_arith && busy && cnt_q > CW'(1)) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: tb/hilo_muldiv_test.sv
module hilo_muldiv_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [31:0] rd_data;
    logic        rd_valid, busy, stall;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    hilo_muldiv uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .src_a(src_a), .src_b(src_b), .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy), .stall(stall)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Starts and ends at a falling edge
    task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        op_valid = 1'b1; op_code = op; src_a = a; src_b = b;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_read(input logic sel_lo, output logic [31:0] data, output int stalls);
        op_valid = 1'b1; op_code = sel_lo ? 3'd7 : 3'd6;
        stalls = 0;
        #1;
        while (stall && stalls < 100) begin
            @(negedge clk); #1;
            stalls++;
        end
        data = rd_data;
        n_checks++;
        if (rd_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL R9: rd_valid got %b expected 1", rd_valid);
        end
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    function automatic int exp_mul_lat(input logic sg, input logic [31:0] a);
        logic [31:0] v;
        int top;
        v = sg ? ((a ^ 32'($signed(a) >>> 21)) | 32'd1) : (a | 32'd1);
        top = 0;
        for (int i = 0; i < 32; i++) if (v[i]) top = i;
        return 7 + (2 - (31 - top) / 11) * 4;
    endfunction

    task automatic run_mul(input logic sg, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] p;
        logic [31:0] d;
        int s;
        if (sg) p = 64'($signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b}));
        else    p = {32'd0, a} * {32'd0, b};
        issue(sg ? 3'd0 : 3'd1, a, b);
        do_read(1'b0, d, s);
        check(sg ? "R2 hi" : "R3 hi", d, p[63:32]);
        check("R4 stall", 32'(s), 32'(exp_mul_lat(sg, a)));
        do_read(1'b1, d, s);
        check(sg ? "R2 lo" : "R3 lo", d, p[31:0]);
        check("R9 no-stall", 32'(s), 32'd0);
    endtask

    task automatic run_div(input logic sg, input logic [31:0] a, input logic [31:0] b, input string tag);
        logic [31:0] q, r, d;
        int s;
        if (b == 0) begin
            r = a;
            q = (sg && a[31]) ? 32'd1 : 32'hFFFF_FFFF;
        end else if (sg && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
            q = 32'h8000_0000; r = 32'd0;
        end else if (sg) begin
            int sa, sb;
            sa = a; sb = b;
            q = 32'(sa / sb); r = 32'(sa % sb);
        end else begin
            q = a / b; r = a % b;
        end
        issue(sg ? 3'd2 : 3'd3, a, b);
        do_read(1'b0, d, s);
        check({tag, " hi"}, d, r);
        check("R5 stall", 32'(s), 32'd37);
        do_read(1'b1, d, s);
        check({tag, " lo"}, d, q);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", {31'd0, busy}, 32'd0);
        do_read(1'b0, d, s);
        check("R1 hi", d, 32'd0);
        check("R1 stall", 32'(s), 32'd0);
        do_read(1'b1, d, s);
        check("R1 lo", d, 32'd0);

        // R2/R3/R4 sweep over the top set bit of src_a
        for (int sh = 0; sh < 32; sh++) begin
            logic [31:0] a;
            a = (32'd1 << sh) | ($urandom & ((32'd1 << sh) - 32'd1));
            run_mul(1'b0, a, $urandom);
            run_mul(1'b1, a, $urandom);
            run_mul(1'b1, ~a, $urandom);
        end
        run_mul(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_mul(1'b1, 32'h8000_0000, 32'h8000_0000);
        run_mul(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        // R5 random divides
        for (int i = 0; i < 24; i++) begin
            run_div(1'b1, $urandom, $urandom >> (i % 28), "R5 sdiv");
            run_div(1'b0, $urandom, $urandom >> (i % 28), "R5 udiv");
        end
        run_div(1'b1, 32'hFFFF_FFF9, 32'd2, "R5 sdiv-neg");
        run_div(1'b1, 32'd7, 32'hFFFF_FFFE, "R5 sdiv-negdiv");
        // R6, R7, R8 corners
        run_div(1'b1, 32'h0000_1234, 32'd0, "R6 pos");
        run_div(1'b1, 32'hF000_0000, 32'd0, "R6 neg");
        run_div(1'b1, 32'd0, 32'd0, "R6 zero");
        run_div(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, "R7");
        run_div(1'b0, 32'h8765_4321, 32'd0, "R8");
        run_div(1'b0, 32'h8000_0000, 32'hFFFF_FFFF, "R5 udiv-big");

        // R9 read after a gap: latency 15, 5 idle cycles
        issue(3'd1, 32'hFFFF_FFFF, 32'd3);
        idle(5);
        do_read(1'b1, d, s);
        check("R9 gap stall", 32'(s), 32'd10);
        check("R9 gap lo", d, 32'hFFFF_FFFD);
        issue(3'd1, 32'd5, 32'd3);
        idle(20);
        do_read(1'b1, d, s);
        check("R9 late stall", 32'(s), 32'd0);

        // R10 move while busy keeps the countdown
        issue(3'd3, 32'd100, 32'd7);
        issue(3'd5, 32'hCAFE_0001, 32'd0);
        do_read(1'b1, d, s);
        check("R10 lo", d, 32'hCAFE_0001);
        check("R10 stall", 32'(s), 32'd36);
        do_read(1'b0, d, s);
        check("R10 rem kept", d, 32'd2);
        issue(3'd4, 32'h0BAD_F00D, 32'd0);
        do_read(1'b0, d, s);
        check("R10 hi idle", d, 32'h0BAD_F00D);
        check("R10 idle stall", 32'(s), 32'd0);

        // R11 restart: multiply (15) then divide after 3 idle cycles
        issue(3'd1, 32'hFFFF_FFFF, 32'd2);
        idle(3);
        issue(3'd3, 32'd50, 32'd8);
        do_read(1'b1, d, s);
        check("R11 stall", 32'(s), 32'd37);
        check("R11 lo", d, 32'd6);
        // R11 restart shortening: divide then fast multiply
        issue(3'd3, 32'd50, 32'd8);
        idle(2);
        issue(3'd1, 32'd3, 32'd4);
        do_read(1'b1, d, s);
        check("R11 short stall", 32'(s), 32'd7);
        check("R11 short lo", d, 32'd12);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule